// File: doc/BRIEF.md
# Timer Clock Select Prescaler

This block turns a 3-bit select code into a one-cycle count-enable tick for a timer/counter. The tick can come from a free-running prescaler on the system clock, which gives the fixed ratios 1, 8, 64, 256 and 1024. It can also come from a chosen edge of an external pin, or be held off entirely. The counter that consumes the tick sits outside this block.

The prescaler runs from reset and never restarts when the code changes. The external pin passes through a two-flop synchronizer and an edge detector. The pin is treated purely as an input here. Whatever drives it, including the chip's own output logic under software control, advances the count. Every tick is registered, so the tick for the code sampled at clock edge `n` appears after edge `n`.

Top module: `timer_clk_sel`

## Requirements
- R1: While `rst_ni` is low, `tick_o` is 0. Select code 3'b000 yields no tick, whatever the pin does. After reset the selector is expected at 3'b000.
- R2: With code 3'b001, `tick_o` is 1 after every clock edge.
- R3: Let `k` count clock edges since reset release, starting at 0. With code 3'b010, the tick after edge `k` is 1 exactly when `k mod 8 == 0`.
- R4: With code 3'b011, the tick after edge `k` is 1 exactly when `k mod 64 == 0`.
- R5: With code 3'b100, the tick after edge `k` is 1 exactly when `k mod 256 == 0`.
- R6: With code 3'b101, the tick after edge `k` is 1 exactly when `k mod 1024 == 0`.
- R7: With code 3'b110, a falling edge on `ext_i` produces one tick. If the pin is 0 at edge `n` and was 1 at edge `n-1`, the tick appears after edge `n+2`.
- R8: With code 3'b111, a rising edge on `ext_i` produces one tick, with the same latency as R7.
- R9: Under codes 3'b000 to 3'b101, the output does not depend on `ext_i`.
- R10: A change of the select code does not restart the prescaler. The divided phases stay locked to the edge count since reset.
- R11: In the edge modes, a pin held at one level produces exactly one tick, and never two ticks on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 3 | Clock select code |
| ext_i | input | 1 | External count pin, asynchronous |
| tick_o | output | 1 | Registered single-cycle count enable |

## Verification
On every cycle, the assertions check four things: the stop and undivided codes, the phase of the /8 and /1024 ratios against an edge counter kept in the checker, and the ban on back-to-back ticks in the edge modes. The bench's behavioural model adds the rest. That covers the /64 and /256 phases and the exact three-edge latency of the pin path. It also shows that pin activity is ignored under the prescaler codes, that the phase stays locked across repeated code changes, and that a long, steady pin level yields a single tick.

// File: rtl/tcs_pkg.sv
package tcs_pkg;
  typedef enum logic [2:0] {
    SEL_STOP     = 3'b000,
    SEL_DIV1     = 3'b001,
    SEL_DIV8     = 3'b010,
    SEL_DIV64    = 3'b011,
    SEL_DIV256   = 3'b100,
    SEL_DIV1024  = 3'b101,
    SEL_EXT_FALL = 3'b110,
    SEL_EXT_RISE = 3'b111
  } sel_e;

  localparam int unsigned PRE_W       = 10;
  localparam int unsigned NUM_TAPS    = 4;
  localparam int unsigned SYNC_STAGES = 2;

  // log2 of each prescaler ratio, index 0 = /8 .. 3 = /1024
  function automatic int unsigned tap_shift(input int unsigned idx);
    case (idx)
      0:       return 3;
      1:       return 6;
      2:       return 8;
      default: return 10;
    endcase
  endfunction
endpackage

// File: rtl/tcs_prescaler.sv
module tcs_prescaler #(
  parameter int unsigned PRE_W    = tcs_pkg::PRE_W,
  parameter int unsigned NUM_TAPS = tcs_pkg::NUM_TAPS
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  output logic [NUM_TAPS-1:0] tap_o
);
  logic [PRE_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
    localparam int unsigned SH = tcs_pkg::tap_shift(g);
    // pulse when the low SH bits wrap to zero
    assign tap_o[g] = (cnt_q[SH-1:0] == '0);
  end
endmodule

// File: rtl/tcs_ext_edge.sv
module tcs_ext_edge #(
  parameter int unsigned SYNC_STAGES = tcs_pkg::SYNC_STAGES
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_i,
  output logic rise_o,
  output logic fall_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q[0] <= 1'b0;
    else         sync_q[0] <= ext_i;
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q[s] <= 1'b0;
      else         sync_q[s] <= sync_q[s-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[SYNC_STAGES-1];
  end

  assign rise_o =  sync_q[SYNC_STAGES-1] & ~prev_q;
  assign fall_o = ~sync_q[SYNC_STAGES-1] &  prev_q;
endmodule

// File: rtl/tcs_tick_mux.sv
module tcs_tick_mux #(
  parameter int unsigned NUM_TAPS = tcs_pkg::NUM_TAPS
) (
  input  logic [2:0]          sel_i,
  input  logic [NUM_TAPS-1:0] tap_i,
  input  logic                rise_i,
  input  logic                fall_i,
  output logic                tick_o
);
  import tcs_pkg::*;

  sel_e sel;
  assign sel = sel_e'(sel_i);

  always_comb begin
    case (sel)
      SEL_STOP:     tick_o = 1'b0;
      SEL_DIV1:     tick_o = 1'b1;
      SEL_DIV8:     tick_o = tap_i[0];
      SEL_DIV64:    tick_o = tap_i[1];
      SEL_DIV256:   tick_o = tap_i[2];
      SEL_DIV1024:  tick_o = tap_i[NUM_TAPS-1];
      SEL_EXT_FALL: tick_o = fall_i;
      SEL_EXT_RISE: tick_o = rise_i;
      default:      tick_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/timer_clk_sel.sv
module timer_clk_sel #(
  parameter int unsigned PRE_W       = tcs_pkg::PRE_W,
  parameter int unsigned NUM_TAPS    = tcs_pkg::NUM_TAPS,
  parameter int unsigned SYNC_STAGES = tcs_pkg::SYNC_STAGES
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] sel_i,
  input  logic       ext_i,
  output logic       tick_o
);
  logic [NUM_TAPS-1:0] tap;
  logic                rise, fall, tick_d, tick_q;

  tcs_prescaler #(.PRE_W(PRE_W), .NUM_TAPS(NUM_TAPS)) i_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tap_o (tap)
  );

  tcs_ext_edge #(.SYNC_STAGES(SYNC_STAGES)) i_ext (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ext_i (ext_i),
    .rise_o(rise),
    .fall_o(fall)
  );

  tcs_tick_mux #(.NUM_TAPS(NUM_TAPS)) i_mux (
    .sel_i (sel_i),
    .tap_i (tap),
    .rise_i(rise),
    .fall_i(fall),
    .tick_o(tick_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tick_q <= 1'b0;
    else         tick_q <= tick_d;
  end

  assign tick_o = tick_q;
endmodule

// File: rtl/timer_clk_sel_chk.sv
module timer_clk_sel_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [2:0] sel_i,
  input logic       tick_o
);
  // independent edge count since reset release
  logic [9:0] cyc_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cyc_q <= '0;
    else         cyc_q <= cyc_q + 1'b1;
  end

  p_stop_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 3'b000) |=> !tick_o);

  p_every_cycle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 3'b001) |=> tick_o);

  p_div8_phase_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 3'b010) |=> (tick_o == ($past(cyc_q[2:0]) == 3'd0)));

  p_div1024_phase_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 3'b101) |=> (tick_o == ($past(cyc_q) == 10'd0)));

  p_no_double_rise_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(sel_i) == 3'b111 && sel_i == 3'b111 && tick_o) |=> !tick_o);

  p_no_double_fall_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(sel_i) == 3'b110 && sel_i == 3'b110 && tick_o) |=> !tick_o);
endmodule

bind timer_clk_sel timer_clk_sel_chk i_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .sel_i (sel_i),
  .tick_o(tick_o)
);

// File: tb/test_timer_clk_sel.sv
module test_timer_clk_sel;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] sel = 3'b000;
  logic       pin = 1'b0;
  logic       tick;

  int tests = 0;
  int fails = 0;
  int k = 0;
  int cycles = 0;
  bit exp_valid = 1'b0;
  bit exp_tick = 1'b0;
  bit done = 1'b0;
  bit hist [3];
  string phase = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  timer_clk_sel i_timer_clk_sel (
    .clk_i (clk),
    .rst_ni(rst_n),
    .sel_i (sel),
    .ext_i (pin),
    .tick_o(tick)
  );

  // behavioural reference: hist[i] = pin sampled i+1 edges ago
  always @(posedge clk) begin
    cycles++;
    if (rst_n) begin
      case (sel)
        3'b000: exp_tick = 1'b0;
        3'b001: exp_tick = 1'b1;
        3'b010: exp_tick = (k % 8) == 0;
        3'b011: exp_tick = (k % 64) == 0;
        3'b100: exp_tick = (k % 256) == 0;
        3'b101: exp_tick = (k % 1024) == 0;
        3'b110: exp_tick = !hist[1] && hist[2];
        default: exp_tick = hist[1] && !hist[2];
      endcase
      hist[2] = hist[1];
      hist[1] = hist[0];
      hist[0] = pin;
      k++;
      exp_valid = 1'b1;
    end
  end

  always @(negedge clk) begin
    if (rst_n && exp_valid && !done) begin
      tests++;
      if (tick !== exp_tick) begin
        fails++;
        $display("FAIL %s: edge %0d sel %b tick %b expected %b", phase, k-1, sel, tick, exp_tick);
      end
    end
  end

  task automatic run(input string ph, input logic [2:0] s, input int n, input int per);
    phase = ph;
    sel = s;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (per > 0 && (i % per) == 0) pin = ~pin;
    end
  endtask

  initial begin
    for (int i = 0; i < 3; i++) hist[i] = 1'b0;
    // R1: reset holds tick low
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      pin = ~pin;
      tests++;
      if (tick !== 1'b0) begin
        fails++;
        $display("FAIL R1: tick in reset %b expected 0", tick);
      end
    end
    pin = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    run("R1", 3'b000, 40, 3);
    run("R2", 3'b001, 30, 0);
    run("R3", 3'b010, 50, 0);
    run("R4", 3'b011, 200, 0);
    run("R5", 3'b100, 600, 0);
    run("R6", 3'b101, 2100, 0);
    run("R7", 3'b110, 120, 5);
    run("R8", 3'b111, 120, 7);
    run("R9", 3'b010, 100, 1);
    run("R9", 3'b101, 1100, 2);
    for (int r = 0; r < 20; r++) begin
      run("R10", 3'b011, 13, 0);
      run("R10", 3'b010, 11, 0);
      run("R10", 3'b100, 17, 0);
    end
    pin = 1'b0;
    run("R11", 3'b111, 60, 0);
    pin = 1'b1;
    run("R11", 3'b111, 60, 0);
    pin = 1'b0;
    run("R11", 3'b110, 60, 0);
    run("R1", 3'b000, 20, 2);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    wait (cycles > WATCHDOG);
    if (!done) begin
      done = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog: cycles %0d expected below %0d", cycles, WATCHDOG);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule